// File: doc/BRIEF.md
# NAND Address Cycle Serializer

This block turns a flat flash address (column, page within block, block number) into the series of byte-wide address cycles that a NAND device takes over its shared 8-bit I/O bus. The device has no separate address pins, so the command stage puts these bytes on the bus between the command bytes.

Two array layouts are supported. In small-page mode the page is 512 data bytes plus 16 spare bytes, and a block holds 32 pages. In large-page mode the page is 2,048 data bytes plus 64 spare bytes, and a block holds 64 pages. The two modes pack the fields into the bytes differently. Small-page mode has no column bit 8 in its address bytes. The block reports that bit on a half-select output, and the command stage uses it to choose the pointer command for the upper half of the page.

A row-only flag drops the column cycles, as needed for block erase. A device-size select adds a fifth cycle in large-page mode for the larger device.

Top module: `nand_addr_ser`

## Requirements
- R1: A start pulse while the block is idle captures all inputs. The first address byte appears on the clock after the start, then one byte per clock, with `addr_latch` and `byte_valid` both high on every emitted byte. A start while bytes are still being emitted is ignored.
- R2: Small-page mode (`large_mode`=0) emits four bytes in this order: `col[7:0]`; `{blk[2:0], page[4:0]}`; `blk[10:3]`; `{6'b0, blk[12:11]}`. `page[5]`, `col[11:9]` and `big_dev` have no effect in this mode.
- R3: `half_sel` is loaded on each accepted start. It takes `col[8]` in small-page mode and 0 in large-page mode, and it holds that value until the next accepted start. Reset clears it to 0.
- R4: Large-page mode (`large_mode`=1) with `big_dev`=0 emits four bytes in this order: `col[7:0]`; `{4'b0, col[11:8]}`; `{blk[1:0], page[5:0]}`; `blk[9:2]`.
- R5: Large-page mode with `big_dev`=1 appends a fifth byte, `{7'b0, blk[10]}`. It follows the other bytes.
- R6: With `row_only`=1 the column bytes are skipped. Small-page mode then emits three bytes and large-page mode emits two or three. The row bytes keep the order and content given in R2, R4 and R5.
- R7: `done` is high for exactly one clock, the clock after the last address byte. During that clock `addr_latch` is low. A start during the `done` clock is accepted.
- R8: After reset, and at all times when no byte is being emitted, `addr_latch`, `byte_valid` and `done` are low and `io_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address sequence |
| large_mode | input | 1 | 1 = large-page layout, 0 = small-page layout |
| big_dev | input | 1 | 1 = the larger device in large-page mode, which adds a fifth cycle |
| row_only | input | 1 | Skip the column cycles |
| col | input | COL_W | Byte column within the page |
| page | input | PAGE_W | Page within the block |
| blk | input | BLK_W | Block number |
| io_out | output | 8 | Address byte for the I/O bus |
| addr_latch | output | 1 | Address-latch qualifier, high on each address byte |
| byte_valid | output | 1 | Per-byte valid strobe |
| done | output | 1 | One-clock pulse after the last byte |
| half_sel | output | 1 | Upper-half pointer select for small-page mode |

## Verification
The layout is tried with addresses that are walking ones and all ones in each field, and with random addresses. A wrong bit position therefore shows up as a byte that differs, and not as a coincidental match. Every pairing of mode, device size and row-only flag is run, and the number of bytes and their content separate the four- and five-cycle sequences from the three- and two-cycle ones. A start held high across a whole sequence shows both that a start during emission is ignored and that a start in the `done` clock is accepted. A second start issued in the middle of a sequence with different inputs shows that the captured address does not change.

// File: rtl/nand_addr_ser.sv
module nand_addr_ser #(
  parameter int COL_W  = 12,
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 13,
  parameter int MAX_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              large_mode,
  input  logic              big_dev,
  input  logic              row_only,
  input  logic [COL_W-1:0]  col,
  input  logic [PAGE_W-1:0] page,
  input  logic [BLK_W-1:0]  blk,
  output logic [7:0]        io_out,
  output logic              addr_latch,
  output logic              byte_valid,
  output logic              done,
  output logic              half_sel
);
  localparam int SH_W  = 8 * MAX_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [7:0] c0, c1, s1, s2, s3, r1, r2, r3;
  logic [SH_W-1:0] seq, sh;
  logic [CNT_W-1:0] nb, left;
  logic done_q, half_q, accept;

  assign c0 = col[7:0];
  assign c1 = {4'b0, col[11:8]};
  assign s1 = {blk[2:0], page[4:0]};
  assign s2 = blk[10:3];
  assign s3 = {6'b0, blk[12:11]};
  assign r1 = {blk[1:0], page[5:0]};
  assign r2 = blk[9:2];
  assign r3 = {7'b0, blk[10]};

  always_comb begin
    seq = '0;
    if (large_mode) begin
      if (row_only) seq[23:0] = {r3, r2, r1};
      else          seq[39:0] = {r3, r2, r1, c1, c0};
      nb = CNT_W'((row_only ? 0 : 2) + (big_dev ? 3 : 2));
    end else begin
      if (row_only) seq[23:0] = {s3, s2, s1};
      else          seq[31:0] = {s3, s2, s1, c0};
      nb = CNT_W'(row_only ? 3 : 4);
    end
  end

  assign accept = start && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      done_q <= 1'b0;
      half_q <= 1'b0;
    end else if (accept) begin
      sh     <= seq;
      left   <= nb;
      done_q <= 1'b0;
      half_q <= !large_mode && col[8];
    end else if (left != '0) begin
      sh     <= sh >> 8;
      left   <= left - 1'b1;
      done_q <= (left == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign addr_latch = (left != '0);
  assign byte_valid = addr_latch;
  assign io_out     = addr_latch ? sh[7:0] : 8'h00;
  assign done       = done_q;
  assign half_sel   = half_q;

  // checking state
  logic [CNT_W-1:0] run_cnt, n_q;
  logic lg_q, ro_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      n_q     <= '0;
      lg_q    <= 1'b0;
      ro_q    <= 1'b0;
    end else if (accept) begin
      run_cnt <= '0;
      n_q     <= nb;
      lg_q    <= large_mode;
      ro_q    <= row_only;
    end else if (addr_latch) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  p_rise_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_latch) |-> $past(start));

  p_small_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch && !lg_q && run_cnt == CNT_W'(ro_q ? 2 : 3)) |-> io_out[7:2] == 6'b0);

  p_half_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch && $past(addr_latch)) |-> $stable(half_sel));

  p_large_col_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch && lg_q && !ro_q && run_cnt == CNT_W'(1)) |-> io_out[7:4] == 4'b0);

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!addr_latch && $past(addr_latch)));

  p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_cnt == n_q);
endmodule

// File: tb/nand_addr_ser_bench.sv
module nand_addr_ser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, large_mode = 1'b0, big_dev = 1'b0, row_only = 1'b0;
  logic [11:0] col = '0;
  logic [5:0]  page = '0;
  logic [12:0] blk = '0;
  logic [7:0] io_out;
  logic addr_latch, byte_valid, done, half_sel;

  always #5 clk = ~clk;

  nand_addr_ser u_nand_addr_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .large_mode(large_mode),
    .big_dev(big_dev), .row_only(row_only), .col(col), .page(page), .blk(blk),
    .io_out(io_out), .addr_latch(addr_latch), .byte_valid(byte_valid),
    .done(done), .half_sel(half_sel));

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [7:0] q[$];
  logic m_ale = 0, m_done = 0, m_half = 0;
  string m_tag = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ale = 0; m_done = 0; m_half = 0; m_tag = "R8";
    end else if (m_ale) begin
      void'(q.pop_front());
      if (q.size() == 0) begin m_ale = 0; m_done = 1; end
      else m_done = 0;
    end else begin
      m_done = 0;
      if (start) begin
        q.delete();
        if (large_mode) begin
          if (!row_only) begin q.push_back(col[7:0]); q.push_back({4'h0, col[11:8]}); end
          q.push_back({blk[1:0], page});
          q.push_back(blk[9:2]);
          if (big_dev) q.push_back({7'b0, blk[10]});
          m_half = 0;
          m_tag = row_only ? "R6" : (big_dev ? "R5" : "R4");
        end else begin
          if (!row_only) q.push_back(col[7:0]);
          q.push_back({blk[2:0], page[4:0]});
          q.push_back(blk[10:3]);
          q.push_back({6'b0, blk[12:11]});
          m_half = col[8];
          m_tag = row_only ? "R6" : "R2";
        end
        m_ale = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) chk("R8", "reset outputs", {io_out, addr_latch, byte_valid, done, half_sel}, 0);
      else begin
        chk("R1", "addr_latch", addr_latch, m_ale);
        chk("R1", "byte_valid", byte_valid, m_ale);
        chk("R7", "done", done, m_done);
        chk("R3", "half_sel", half_sel, m_half);
        if (m_ale) chk(m_tag, "io_out", io_out, q[0]);
        else chk("R8", "idle io_out", io_out, 0);
      end
    end
  end

  task automatic issue(input bit lg, input bit bg, input bit ro,
                       input logic [11:0] c, input logic [5:0] p, input logic [12:0] b);
    @(negedge clk);
    large_mode = lg; big_dev = bg; row_only = ro; col = c; page = p; blk = b; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_ale || m_done) @(negedge clk);
  endtask

  task automatic run(input bit lg, input bit bg, input bit ro,
                     input logic [11:0] c, input logic [5:0] p, input logic [12:0] b);
    issue(lg, bg, ro, c, p, b);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 / R4 / R5 / R6: each combination with walking-one and all-ones fields
    for (int m = 0; m < 8; m++) begin
      run(m[0], m[1], m[2], 12'hFFF, 6'h3F, 13'h1FFF);
      for (int k = 0; k < 13; k++)
        run(m[0], m[1], m[2], 12'(1 << (k % 12)), 6'(1 << (k % 6)), 13'(1 << k));
    end
    // R3: half select on and off in small mode, cleared by large mode
    run(0, 0, 0, 12'h100, 6'h01, 13'h0001);
    run(0, 0, 1, 12'h0FF, 6'h02, 13'h0002);
    run(0, 0, 0, 12'h1AB, 6'h03, 13'h0003);
    run(1, 0, 0, 12'h1AB, 6'h04, 13'h0004);
    // R1: restart in the middle of a sequence is ignored
    issue(1, 1, 0, 12'h5A5, 6'h15, 13'h0555);
    @(negedge clk);
    large_mode = 0; col = 12'h1C3; page = 6'h2A; blk = 13'h1AAA; start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
    // R7: start held high, re-accepted on each done clock
    @(negedge clk);
    large_mode = 0; big_dev = 0; row_only = 1; col = 12'h123; page = 6'h11; blk = 13'h0F0F; start = 1;
    repeat (14) @(negedge clk);
    start = 0;
    wait_idle();
    // random addresses
    for (int i = 0; i < 300; i++)
      run($urandom_range(1), $urandom_range(1), $urandom_range(1),
          12'($urandom), 6'($urandom), 13'($urandom));
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule